// File: doc/BRIEF.md
# Polyphase Interpolating Shaping FIR

This block shapes and upsamples a baseband I/Q stream. It pulls one complex input sample from a first-word-fall-through FIFO each time it needs one, and produces L output samples per input sample, with L selectable as 4, 8 or 16. Each output sample is the dot product of one polyphase branch of a programmable impulse response with the S most recent inputs. The span S can be set from 4 to 16 input samples, and L×S never exceeds 256 coefficients. One multiply-accumulate per channel is time-shared over the taps, so an output costs S clocks and an input sample costs L×S clocks.

Coefficients are written through a plain address/data port. The I channel can be delayed by half an input sample, which places it L/2 output positions behind Q, as offset QPSK requires. Interpolation factor, span and offset enable are sampled only on a soft clear. The soft clear also empties the delay line and restarts the schedule.

Top module: `poly_shape_fir`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first `soft_clr`, `out_valid` and `fifo_req` stay 0.
- R2: A cycle with `soft_clr` high latches the configuration, zeroes the delay line and the accumulators, and raises `fifo_req` in the next cycle, during which `out_valid` is 0.
- R3: The first `out_valid` pulse comes S+1 clocks after the first request. Later pulses follow every S clocks, each lasting one cycle.
- R4: After the first request, `fifo_req` pulses for one cycle every L×S clocks. The sample on `fifo_i`/`fifo_q` is taken at the rising edge that ends a request cycle.
- R5: `cfg_interp_sel` encodes L as 0 → 4, 1 → 8, 2 or 3 → 16.
- R6: `cfg_span` gives S directly. Only values from 4 to 16 are supported.
- R7: With input samples x[0], x[1], … and no offset, output number k = n·L + p (p < L) equals Σ over t < S of c[p·S + t]·x[n − t]. Here c[a] is the coefficient at address a, and x at a negative index is 0.
- R8: Each sum is rounded by adding 2^14 and shifting right arithmetically by 15. The result is saturated to the signed 16-bit range [−32768, 32767].
- R9: A request made while `fifo_empty` is high shifts a zero sample into both channels.
- R10: With `cfg_offset_en` latched at 1, I output k equals the R7 value of output k − L/2, and is 0 when k − L/2 is negative. Q is unaffected.
- R11: A write with `coef_we` high stores the signed 16-bit `coef_wdata` at `coef_addr`. Every product computed after that edge uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Latch configuration, clear delay line, restart |
| cfg_interp_sel | input | 2 | Interpolation factor code |
| cfg_span | input | 5 | Impulse-response span in input samples |
| cfg_offset_en | input | 1 | Half-input-sample delay on I |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 8 | Coefficient address, phase·S + tap |
| coef_wdata | input | 16 | Signed coefficient value |
| fifo_req | output | 1 | Request for the next input sample |
| fifo_empty | input | 1 | FIFO has no data; a zero is used instead |
| fifo_i | input | 16 | Signed I sample at the FIFO head |
| fifo_q | input | 16 | Signed Q sample at the FIFO head |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Signed shaped I output |
| out_q | output | 16 | Signed shaped Q output |

## Verification
The first request is due in the cycle right after the soft clear. The first output is due S+1 clocks after that request, further outputs every S clocks, and further requests every L×S clocks. The bench samples on falling edges and stamps each request and each output with a cycle count, then compares the measured spacings with these figures. Its expected samples are computed from R7 to R10 and queued at the clear. The monitor pops one pair on each `out_valid`, so a result that arrives early, late or out of order misaligns the queue and is reported.

// File: rtl/psf_pkg.sv
// Shared types and helpers of the polyphase shaping filter.
// Assumes: interpolation factors are powers of two no larger than 16.
package psf_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_t;

    // Decode the interpolation code into the factor L.
    function automatic logic [4:0] interp_of(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd4;
            2'd1:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/psf_coef_bank.sv
// Coefficient store with one write port and two asynchronous read ports
// (one for the I branch, one for the Q branch).
// Assumes: contents are written before use; there is no reset of the array.
module psf_coef_bank #(
    parameter int CW    = 16,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [CW-1:0] wdata,
    input  logic [AW-1:0]        raddr_a,
    input  logic [AW-1:0]        raddr_b,
    output logic signed [CW-1:0] rdata_a,
    output logic signed [CW-1:0] rdata_b
);
    logic signed [CW-1:0] mem [DEPTH];

    // Store a coefficient on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/psf_delay_line.sv
// Sample history for I and Q. Entry 0 holds the newest sample.
// Assumes: clr has priority over shift.
module psf_delay_line #(
    parameter int DW  = 16,
    parameter int LEN = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 shift,
    input  logic signed [DW-1:0] din_i,
    input  logic signed [DW-1:0] din_q,
    output logic signed [DW-1:0] hist_i [LEN],
    output logic signed [DW-1:0] hist_q [LEN]
);
    for (genvar k = 0; k < LEN; k++) begin : g_stage
        if (k == 0) begin : g_head
            // Head stage: take the new sample.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    hist_i[0] <= '0;
                    hist_q[0] <= '0;
                end else if (shift) begin
                    hist_i[0] <= din_i;
                    hist_q[0] <= din_q;
                end
            end
        end else begin : g_body
            // Body stage: take the sample from the stage before.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    hist_i[k] <= '0;
                    hist_q[k] <= '0;
                end else if (shift) begin
                    hist_i[k] <= hist_i[k-1];
                    hist_q[k] <= hist_q[k-1];
                end
            end
        end
    end
endmodule

// File: rtl/psf_sequencer.sv
// Walks output phase and tap. After a clear it makes one load cycle that
// requests the first sample, then runs S tap cycles per phase and L phases
// per input sample. It requests the next sample on the last tap of the
// last phase.
// Assumes: span >= 2, interp >= 1.
module psf_sequencer
    import psf_pkg::*;
#(
    parameter int MAX_INTERP = 16,
    parameter int MAX_SPAN   = 16,
    localparam int PW        = $clog2(MAX_INTERP),
    localparam int TW        = $clog2(MAX_SPAN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [PW:0]   interp,
    input  logic [TW:0]   span,
    output logic [PW-1:0] phase,
    output logic [TW-1:0] tap,
    output logic          mac_en,
    output logic          last_tap,
    output logic          req
);
    seq_state_t state;
    logic       last_phase;

    // Decode the strobes of the current cycle.
    always_comb begin
        mac_en     = (state == SEQ_RUN);
        last_tap   = mac_en && ({1'b0, tap} == span - 1'b1);
        last_phase = ({1'b0, phase} == interp - 1'b1);
        req        = (state == SEQ_LOAD) || (last_tap && last_phase);
    end

    // Advance state, tap and phase counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            phase <= '0;
            tap   <= '0;
        end else if (clr) begin
            state <= SEQ_LOAD;
            phase <= '0;
            tap   <= '0;
        end else begin
            case (state)
                SEQ_LOAD: state <= SEQ_RUN;
                SEQ_RUN: begin
                    if (last_tap) begin
                        tap   <= '0;
                        phase <= last_phase ? '0 : phase + 1'b1;
                    end else begin
                        tap <= tap + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/poly_shape_fir.sv
// Top of the polyphase interpolating shaping filter. One MAC per channel,
// S clocks per output sample. The I channel may be delayed by L/2 output
// positions: it uses the phase p - L/2 and, when that wraps, one sample
// older history. The output is rounded to nearest and saturated.
// Assumes: L*S <= DEPTH, 4 <= S <= MAX_SPAN; configuration is sampled on soft_clr.
module poly_shape_fir
    import psf_pkg::*;
#(
    parameter int DW         = 16,
    parameter int CW         = 16,
    parameter int MAX_SPAN   = 16,
    parameter int MAX_INTERP = 16,
    parameter int DEPTH      = 256,
    localparam int AW        = $clog2(DEPTH),
    localparam int TW        = $clog2(MAX_SPAN),
    localparam int PW        = $clog2(MAX_INTERP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic [1:0]    cfg_interp_sel,
    input  logic [TW:0]   cfg_span,
    input  logic          cfg_offset_en,
    input  logic          coef_we,
    input  logic [AW-1:0] coef_addr,
    input  logic [CW-1:0] coef_wdata,
    output logic          fifo_req,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_i,
    input  logic [DW-1:0] fifo_q,
    output logic          out_valid,
    output logic [DW-1:0] out_i,
    output logic [DW-1:0] out_q
);
    localparam int LEN   = MAX_SPAN + 1;
    localparam int HW    = $clog2(LEN);
    localparam int ACC_W = DW + CW + TW;
    localparam int ADW   = PW + TW + 2;
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (CW - 2);

    logic [PW:0]   interp_q;
    logic [TW:0]   span_q;
    logic          offset_q;
    logic [PW-1:0] phase;
    logic [TW-1:0] tap;
    logic          mac_en, last_tap;

    logic signed [DW-1:0] hist_i [LEN];
    logic signed [DW-1:0] hist_q [LEN];
    logic signed [DW-1:0] din_i, din_q;
    logic signed [CW-1:0] coef_i, coef_q;
    logic [AW-1:0]        addr_i, addr_q;
    logic [PW:0]          shift_amt, phase_i;
    logic                 wrap_i;
    logic [HW-1:0]        hidx_i;
    logic signed [DW+CW-1:0] prod_i, prod_q;
    logic signed [ACC_W-1:0] acc_i, acc_q, sum_i, sum_q;

    // Round to nearest and saturate an accumulated sum to DW bits.
    function automatic logic [DW-1:0] round_sat(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] r;
        r = (v + HALF_LSB) >>> (CW - 1);
        if (r[ACC_W-1:DW-1] == '0 || r[ACC_W-1:DW-1] == '1)
            return r[DW-1:0];
        return r[ACC_W-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    endfunction

    // Latch the configuration on a soft clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interp_q <= (PW+1)'(4);
            span_q   <= (TW+1)'(4);
            offset_q <= 1'b0;
        end else if (soft_clr) begin
            interp_q <= (PW+1)'(interp_of(cfg_interp_sel));
            span_q   <= cfg_span;
            offset_q <= cfg_offset_en;
        end
    end

    psf_sequencer #(.MAX_INTERP(MAX_INTERP), .MAX_SPAN(MAX_SPAN)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .interp(interp_q), .span(span_q),
        .phase(phase), .tap(tap), .mac_en(mac_en),
        .last_tap(last_tap), .req(fifo_req)
    );

    assign din_i = fifo_empty ? '0 : $signed(fifo_i);
    assign din_q = fifo_empty ? '0 : $signed(fifo_q);

    psf_delay_line #(.DW(DW), .LEN(LEN)) u_hist (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .shift(fifo_req),
        .din_i(din_i), .din_q(din_q), .hist_i(hist_i), .hist_q(hist_q)
    );

    // Work out the I branch phase and history offset for the half-sample delay.
    always_comb begin
        shift_amt = offset_q ? (interp_q >> 1) : '0;
        wrap_i    = ({1'b0, phase} < shift_amt);
        phase_i   = wrap_i ? ({1'b0, phase} + interp_q - shift_amt)
                           : ({1'b0, phase} - shift_amt);
        hidx_i    = HW'(tap) + HW'(wrap_i);
        addr_i    = AW'(ADW'(phase_i) * ADW'(span_q) + ADW'(tap));
        addr_q    = AW'(ADW'(phase) * ADW'(span_q) + ADW'(tap));
    end

    psf_coef_bank #(.CW(CW), .DEPTH(DEPTH)) u_coef (
        .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata($signed(coef_wdata)),
        .raddr_a(addr_i), .raddr_b(addr_q), .rdata_a(coef_i), .rdata_b(coef_q)
    );

    // Form this tap's products and running sums.
    always_comb begin
        prod_i = coef_i * hist_i[hidx_i];
        prod_q = coef_q * hist_q[tap];
        sum_i  = (tap == '0 ? '0 : acc_i) + ACC_W'(prod_i);
        sum_q  = (tap == '0 ? '0 : acc_q) + ACC_W'(prod_q);
    end

    // Accumulate taps and register the finished output sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_i     <= '0;
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else if (soft_clr) begin
            acc_i     <= '0;
            acc_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= last_tap;
            if (mac_en) begin
                acc_i <= sum_i;
                acc_q <= sum_q;
            end
            if (last_tap) begin
                out_i <= round_sat(sum_i);
                out_q <= round_sat(sum_q);
            end
        end
    end
endmodule

// File: rtl/psf_checker.sv
// Protocol checks on the shaping filter: start-up, request and output cadence.
// Assumes: bound into poly_shape_fir, reading its latched span.
module psf_checker #(
    parameter int MAX_SPAN = 16,
    localparam int TW      = $clog2(MAX_SPAN)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_clr,
    input logic        fifo_req,
    input logic        out_valid,
    input logic [TW:0] span_q
);
    logic        armed;
    logic        seen;
    logic [TW:0] gap;

    // Note whether a soft clear has happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else if (soft_clr) armed <= 1'b1;
    end

    // Count clocks since the previous output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            seen <= 1'b0;
            gap  <= '0;
        end else if (out_valid) begin
            seen <= 1'b1;
            gap  <= (TW+1)'(1);
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    assert_no_early_output_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || fifo_req) |-> armed);

    assert_clear_requests_R2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (fifo_req && !out_valid));

    assert_output_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen) |-> (gap == span_q));

    assert_single_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_req && !soft_clr) |=> !fifo_req);
endmodule

bind poly_shape_fir psf_checker #(.MAX_SPAN(MAX_SPAN)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .fifo_req(fifo_req),
    .out_valid(out_valid), .span_q(span_q)
);

// File: tb/poly_shape_fir_tb.sv
// Scoreboard bench: the driver queues expected outputs per case, and the
// monitor pops and compares them and times requests and outputs.
module poly_shape_fir_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, soft_clr, cfg_offset_en, coef_we;
    logic [1:0]  cfg_interp_sel;
    logic [4:0]  cfg_span;
    logic [7:0]  coef_addr;
    logic [15:0] coef_wdata;
    logic        fifo_req, fifo_empty, out_valid;
    logic [15:0] fifo_i, fifo_q, out_i, out_q;

    poly_shape_fir u_dut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .cfg_interp_sel(cfg_interp_sel), .cfg_span(cfg_span),
        .cfg_offset_en(cfg_offset_en), .coef_we(coef_we),
        .coef_addr(coef_addr), .coef_wdata(coef_wdata),
        .fifo_req(fifo_req), .fifo_empty(fifo_empty),
        .fifo_i(fifo_i), .fifo_q(fifo_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;
    int xi [64];
    int xq [64];
    int cm [256];
    int cur_L = 4, cur_S = 4, cur_off = 0, cur_N = 0;
    int fidx = 0;
    bit case_on = 0, have_req = 0, have_out = 0;
    int last_req = 0, first_req = 0, last_out = 0;
    int qi [$];
    int qq [$];
    string ti [$];
    string tq [$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // FIFO model with first-word-fall-through data; it runs empty after cur_N samples.
    always @(posedge clk) begin
        if (soft_clr) fidx <= 0;
        else if (fifo_req) fidx <= fidx + 1;
    end
    always_comb begin
        fifo_empty = (fidx >= cur_N);
        fifo_i = (fidx < cur_N && fidx < 64) ? 16'(xi[fidx]) : 16'h7abc;
        fifo_q = (fidx < cur_N && fidx < 64) ? 16'(xq[fidx]) : 16'h7abc;
    end

    function automatic longint dot(input bit chq, input int n, input int p);
        longint s = 0;
        for (int t = 0; t < cur_S; t++) begin
            int m = n - t;
            longint x = 0;
            if (m >= 0 && m < cur_N) x = chq ? xq[m] : xi[m];
            s += longint'(cm[p*cur_S + t]) * x;
        end
        return s;
    endfunction

    function automatic int rnd(input longint s);
        longint r = (s + 16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    // Monitor: cadence checks and scoreboard comparison.
    always @(negedge clk) begin
        cyc++;
        if (case_on) begin
            if (fifo_req) begin
                if (have_req)
                    chk(cyc - last_req == cur_L*cur_S, "R4 R5 request spacing", cyc - last_req, cur_L*cur_S);
                else
                    first_req = cyc;
                have_req = 1;
                last_req = cyc;
            end
            if (out_valid && qi.size() > 0) begin
                int ei, eq;
                string tgi, tgq;
                if (have_out)
                    chk(cyc - last_out == cur_S, "R3 R6 output spacing", cyc - last_out, cur_S);
                else
                    chk(cyc - first_req == cur_S + 1, "R2 R3 first output latency", cyc - first_req, cur_S + 1);
                have_out = 1;
                last_out = cyc;
                ei = qi.pop_front(); eq = qq.pop_front();
                tgi = ti.pop_front(); tgq = tq.pop_front();
                chk($signed(out_i) == ei, tgi, $signed(out_i), ei);
                chk($signed(out_q) == eq, tgq, $signed(out_q), eq);
            end
        end
    end

    // Driver: load coefficients and data, clear, queue expectations, wait for drain.
    task automatic run_case(input int sel_v, input int s_v, input int off_v, input int n_v, input bit sat);
        cur_L = (sel_v == 0) ? 4 : (sel_v == 1) ? 8 : 16;
        cur_S = s_v; cur_off = off_v; cur_N = n_v;
        for (int n = 0; n < n_v; n++) begin
            xi[n] = sat ? 32767 : (((n*53 + 7) % 211) - 105) * 150;
            xq[n] = sat ? -32768 : (((n*29 + 3) % 173) - 86) * 180;
        end
        // R11: coefficients written through the port, used from the next clear on.
        for (int a = 0; a < cur_L*cur_S; a++) begin
            cm[a] = sat ? 32767 : (((a*37 + 11 + s_v) % 97) - 48) * 300;
            @(negedge clk);
            coef_we = 1; coef_addr = 8'(a); coef_wdata = 16'(cm[a]);
        end
        @(negedge clk);
        coef_we = 0;
        cfg_interp_sel = 2'(sel_v); cfg_span = 5'(s_v); cfg_offset_en = off_v[0];
        soft_clr = 1;
        @(posedge clk);
        #1;
        soft_clr = 0;
        have_req = 0; have_out = 0;
        for (int k = 0; k < (n_v + 2)*cur_L; k++) begin
            int n = k / cur_L, p = k % cur_L;
            int kk = k - (off_v ? cur_L/2 : 0);
            string base = sat ? "R8 saturation" : (n >= n_v ? "R9 empty fifo zeros" : "R7 R11 shaping");
            qq.push_back(rnd(dot(1, n, p)));
            tq.push_back({base, " Q"});
            qi.push_back(kk < 0 ? 0 : rnd(dot(0, kk / cur_L, kk % cur_L)));
            ti.push_back(off_v ? {"R10 offset I ", base} : {base, " I"});
        end
        case_on = 1;
        while (qi.size() > 0) @(negedge clk);
        case_on = 0;
    endtask

    initial begin
        rst_n = 0; soft_clr = 0; coef_we = 0; coef_addr = 0; coef_wdata = 0;
        cfg_interp_sel = 0; cfg_span = 5'd4; cfg_offset_en = 0;
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
        chk(fifo_req == 0, "R1 reset fifo_req", fifo_req, 0);
        rst_n = 1;
        repeat (6) @(negedge clk);
        chk(out_valid == 0, "R1 idle before clear out_valid", out_valid, 0);
        chk(fifo_req == 0, "R1 idle before clear fifo_req", fifo_req, 0);
        run_case(0, 4, 0, 6, 0);
        run_case(1, 6, 1, 5, 0);
        run_case(2, 16, 0, 4, 1);
        run_case(2, 5, 1, 3, 0);
        run_case(3, 9, 0, 4, 0);
        run_case(0, 16, 1, 7, 1);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1500000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule